// File: doc/BRIEF.md
# SPI Word Buffering Controller

This block sits between software and the serial shifter of an SPI module and holds the words in flight in both directions. The transmit side takes words that software pushes and hands them, oldest first, to the shifter. The receive side takes words from the shifter and lets software pop them in arrival order. Each side normally runs as a four-entry queue. A per-side switch turns that queue into a plain double buffer with room for two words: one holding register and the shifter's own register.

A control write port carries a halt bit, the two queue-switch bits, two one-shot flush bits and a write-one-to-clear bit for the receive overflow flag. The halt bit comes up set. While it is set, all data-path state is frozen, which models the functional clock being stopped. The queue-switch bits can only be changed while the block is running.

A receive flush leaves the counter at zero. If the overflow flag is still set when the flush happens, the word that was dropped stays at the read port as a stale entry. Software has to discard it with a single pop before the next frame lands. If it does not, that stale word is delivered ahead of the new one.

Top module: `spi_buf_ctrl`

## Requirements
- R1: After reset `halt_o` is 1, `tx_nofifo_o` and `rx_nofifo_o` are 0, both levels are 0, `tx_full` is 0 and `rx_ovf` is 0.
- R2: While `halt_o` is 1, pushes, takes, puts, pops and both flushes have no effect on levels or data. The control register still accepts writes.
- R3: A control write always updates the halt bit. The two queue-switch bits are updated only if `halt_o` was 0 before that write; otherwise they keep their value.
- R4: With `tx_nofifo_o`=0 the transmit side holds up to 4 words, presented on `tx_word` in push order. `tx_full` is 1 at level 4, and a push while full is dropped.
- R5: With `tx_nofifo_o`=1 the transmit capacity is 2. `tx_full` is 1 at level 2, and a third push is dropped.
- R6: With `rx_nofifo_o`=0 the receive side holds up to 4 words, shown on `rx_rdata` in arrival order. `rx_avail` is 1 whenever `rx_level` is non-zero.
- R7: With `rx_nofifo_o`=1 the receive capacity is 2.
- R8: A put while the receive level is at capacity drops the word and sets `rx_ovf`. This holds even if a pop happens in the same cycle. `rx_ovf` stays 1 until a control write with the overflow-clear bit set, and a new overflow in that same cycle wins.
- R9: A control write with the transmit-flush bit at 1 makes `tx_level` 0 on the next cycle and overrides a push or take in the same cycle. With the bit at 0 the write does not change the level. The flush bit holds no state.
- R10: A control write with the receive-flush bit at 1 makes `rx_level` 0 on the next cycle and overrides a put or pop in the same cycle. A write with the bit at 0 leaves the level unchanged. `rx_ovf` is not changed by a flush.
- R11: A receive flush while `rx_ovf` is 1 leaves `rx_level` at 0 with the last dropped word on `rx_rdata`. One pop discards it. If a put arrives before that pop, `rx_level` becomes 2 and the stale word is read first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_halt | input | 1 | Halt bit value to write |
| cfg_tx_nofifo | input | 1 | Transmit double-buffer select to write |
| cfg_rx_nofifo | input | 1 | Receive double-buffer select to write |
| cfg_tx_flush | input | 1 | One-shot transmit flush |
| cfg_rx_flush | input | 1 | One-shot receive flush |
| cfg_ovf_w1c | input | 1 | Write 1 to clear the overflow flag |
| halt_o | output | 1 | Current halt bit |
| tx_nofifo_o | output | 1 | Current transmit double-buffer select |
| rx_nofifo_o | output | 1 | Current receive double-buffer select |
| tx_push | input | 1 | Software pushes a transmit word |
| tx_wdata | input | DW | Transmit word from software |
| tx_full | output | 1 | Transmit side at capacity |
| tx_level | output | CW | Transmit fill count |
| tx_avail | output | 1 | A word is ready for the shifter |
| tx_word | output | DW | Oldest transmit word |
| tx_take | input | 1 | Shifter consumes the oldest word |
| rx_put | input | 1 | Shifter delivers a received word |
| rx_pdata | input | DW | Received word from the shifter |
| rx_pop | input | 1 | Software pops the oldest received word |
| rx_rdata | output | DW | Word at the receive read port |
| rx_avail | output | 1 | Receive level non-zero |
| rx_level | output | CW | Receive fill count |
| rx_ovf | output | 1 | Sticky receive overflow flag |

## Verification
The assertions watch every cycle for the following:
- levels stay frozen while halted;
- queue-switch bits stay locked while halted;
- a flush empties its side on the next cycle;
- the overflow flag is set by a put into a full side and is not cleared without the clear bit;
- the full flag agrees with the capacity of the selected mode.

Only the directed scenarios can show word ordering, the dropping of excess words, the clear bits having no storage, and the stale-entry hazard. In those scenarios a flush after overflow exposes the dropped word, and that word is then either discarded by one pop or delivered ahead of a new frame.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    typedef struct packed {
        logic halt;
        logic tx_nofifo;
        logic rx_nofifo;
    } buf_cfg_t;

    localparam buf_cfg_t CFG_RESET = '{halt: 1'b1, tx_nofifo: 1'b0, rx_nofifo: 1'b0};

endpackage

// File: rtl/spi_buf_cfg.sv
module spi_buf_cfg
    import spi_buf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  logic     halt_w,
    input  logic     tx_nofifo_w,
    input  logic     rx_nofifo_w,
    output buf_cfg_t cfg
);

    buf_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.halt = halt_w;
            // queue-switch bits are locked while the block is halted
            if (!cfg_q.halt) begin
                cfg_d.tx_nofifo = tx_nofifo_w;
                cfg_d.rx_nofifo = rx_nofifo_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/spi_buf_txq.sv
module spi_buf_txq #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int BYP   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       bypass,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       take,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       avail,
    output logic [DW-1:0]              word
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } txq_t;

    txq_t s_d, s_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic [CW-1:0] cap;
    logic          is_full;
    logic          do_push;
    logic          do_take;

    always_comb begin
        cap     = bypass ? CW'(BYP) : CW'(DEPTH);
        is_full = (s_q.cnt >= cap);
        do_push = push && !is_full;
        do_take = take && (s_q.cnt != '0);
        s_d     = s_q;
        if (run) begin
            if (flush) begin
                s_d.cnt = '0;
                s_d.rd  = s_q.wr;
            end else begin
                if (do_push) begin
                    s_d.mem[s_q.wr] = wdata;
                    s_d.wr          = nxt(s_q.wr);
                end
                if (do_take) s_d.rd = nxt(s_q.rd);
                s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_take);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.cnt;
    assign full  = is_full;
    assign avail = (s_q.cnt != '0);
    assign word  = s_q.mem[s_q.rd];

endmodule

// File: rtl/spi_buf_rxq.sv
module spi_buf_rxq #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int BYP   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       bypass,
    input  logic                       flush,
    input  logic                       put,
    input  logic [DW-1:0]              pdata,
    input  logic                       pop,
    input  logic                       ovf_clr,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       avail,
    output logic [DW-1:0]              rdata,
    output logic                       ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
        logic                     ovf;
        logic                     stale;
        logic [DW-1:0]            spill;
    } rxq_t;

    rxq_t s_d, s_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] prv(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
    endfunction

    logic [CW-1:0] cap;
    logic          is_full;
    logic          acc;
    logic          drop;
    logic          pop_ok;
    logic [CW-1:0] inc;
    logic [CW-1:0] dec;

    always_comb begin
        cap     = bypass ? CW'(BYP) : CW'(DEPTH);
        is_full = (s_q.cnt >= cap);
        acc     = put && !is_full;
        drop    = put && is_full;
        pop_ok  = pop && ((s_q.cnt != '0) || s_q.stale);
        inc     = '0;
        dec     = '0;
        if (acc)                    inc = (s_q.stale && !pop_ok) ? CW'(2) : CW'(1);
        if (pop_ok && !s_q.stale)   dec = CW'(1);

        s_d = s_q;
        if (ovf_clr) s_d.ovf = 1'b0;
        if (run) begin
            if (flush) begin
                s_d.cnt = '0;
                if (s_q.ovf) begin
                    // dropped word lingers one slot behind the write pointer
                    s_d.rd               = prv(s_q.wr);
                    s_d.mem[prv(s_q.wr)] = s_q.spill;
                    s_d.stale            = 1'b1;
                end else begin
                    s_d.rd    = s_q.wr;
                    s_d.stale = 1'b0;
                end
            end else begin
                if (acc) begin
                    s_d.mem[s_q.wr] = pdata;
                    s_d.wr          = nxt(s_q.wr);
                end
                if (drop) begin
                    s_d.ovf   = 1'b1;
                    s_d.spill = pdata;
                end
                if (pop_ok) s_d.rd = nxt(s_q.rd);
                if (acc || pop_ok) s_d.stale = 1'b0;
                s_d.cnt = s_q.cnt + inc - dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.cnt;
    assign avail = (s_q.cnt != '0);
    assign rdata = s_q.mem[s_q.rd];
    assign ovf   = s_q.ovf;

endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
    import spi_buf_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 4,
    parameter int BYP_DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_halt,
    input  logic                       cfg_tx_nofifo,
    input  logic                       cfg_rx_nofifo,
    input  logic                       cfg_tx_flush,
    input  logic                       cfg_rx_flush,
    input  logic                       cfg_ovf_w1c,
    output logic                       halt_o,
    output logic                       tx_nofifo_o,
    output logic                       rx_nofifo_o,
    input  logic                       tx_push,
    input  logic [DW-1:0]              tx_wdata,
    output logic                       tx_full,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic                       tx_avail,
    output logic [DW-1:0]              tx_word,
    input  logic                       tx_take,
    input  logic                       rx_put,
    input  logic [DW-1:0]              rx_pdata,
    input  logic                       rx_pop,
    output logic [DW-1:0]              rx_rdata,
    output logic                       rx_avail,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       rx_ovf
);

    buf_cfg_t cfg;
    logic     run;

    spi_buf_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .halt_w      (cfg_halt),
        .tx_nofifo_w (cfg_tx_nofifo),
        .rx_nofifo_w (cfg_rx_nofifo),
        .cfg         (cfg)
    );

    assign run         = !cfg.halt;
    assign halt_o      = cfg.halt;
    assign tx_nofifo_o = cfg.tx_nofifo;
    assign rx_nofifo_o = cfg.rx_nofifo;

    spi_buf_txq #(.DW(DW), .DEPTH(DEPTH), .BYP(BYP_DEPTH)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .bypass (cfg.tx_nofifo),
        .flush  (cfg_we && cfg_tx_flush),
        .push   (tx_push),
        .wdata  (tx_wdata),
        .take   (tx_take),
        .level  (tx_level),
        .full   (tx_full),
        .avail  (tx_avail),
        .word   (tx_word)
    );

    spi_buf_rxq #(.DW(DW), .DEPTH(DEPTH), .BYP(BYP_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .bypass  (cfg.rx_nofifo),
        .flush   (cfg_we && cfg_rx_flush),
        .put     (rx_put),
        .pdata   (rx_pdata),
        .pop     (rx_pop),
        .ovf_clr (cfg_we && cfg_ovf_w1c),
        .level   (rx_level),
        .avail   (rx_avail),
        .rdata   (rx_rdata),
        .ovf     (rx_ovf)
    );

endmodule

// File: rtl/spi_buf_chk.sv
module spi_buf_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int BYP   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic                       cfg_tx_flush,
    input logic                       cfg_rx_flush,
    input logic                       cfg_ovf_w1c,
    input logic                       halt_o,
    input logic                       tx_nofifo_o,
    input logic                       rx_nofifo_o,
    input logic                       tx_full,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic                       rx_put,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic                       rx_ovf
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] rx_cap;
    assign rx_cap = rx_nofifo_o ? CW'(BYP) : CW'(DEPTH);

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> ($stable(tx_level) && $stable(rx_level)));

    // R3
    switch_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> ($stable(tx_nofifo_o) && $stable(rx_nofifo_o)));

    // R5
    tx_byp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nofifo_o && tx_level == CW'(BYP)) |-> tx_full);

    // R4
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= CW'(DEPTH));

    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_tx_flush && !halt_o) |=> (tx_level == '0));

    // R10
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_rx_flush && !halt_o) |=> (rx_level == '0));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_put && !halt_o && rx_level >= rx_cap && !(cfg_we && cfg_rx_flush)) |=> rx_ovf);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !(cfg_we && cfg_ovf_w1c)) |=> rx_ovf);

endmodule

bind spi_buf_ctrl spi_buf_chk #(.DW(DW), .DEPTH(DEPTH), .BYP(BYP_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_tx_flush (cfg_tx_flush),
    .cfg_rx_flush (cfg_rx_flush),
    .cfg_ovf_w1c  (cfg_ovf_w1c),
    .halt_o       (halt_o),
    .tx_nofifo_o  (tx_nofifo_o),
    .rx_nofifo_o  (rx_nofifo_o),
    .tx_full      (tx_full),
    .tx_level     (tx_level),
    .rx_put       (rx_put),
    .rx_level     (rx_level),
    .rx_ovf       (rx_ovf)
);

// File: tb/sim_spi_buf_ctrl.sv
module sim_spi_buf_ctrl;

    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_halt = 0, cfg_tx_nofifo = 0, cfg_rx_nofifo = 0;
    logic cfg_tx_flush = 0, cfg_rx_flush = 0, cfg_ovf_w1c = 0;
    logic halt_o, tx_nofifo_o, rx_nofifo_o;
    logic tx_push = 0, tx_take = 0, rx_put = 0, rx_pop = 0;
    logic [DW-1:0] tx_wdata = '0, rx_pdata = '0;
    logic tx_full, tx_avail, rx_avail, rx_ovf;
    logic [DW-1:0] tx_word, rx_rdata;
    logic [2:0] tx_level, rx_level;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_buf_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_halt(cfg_halt),
        .cfg_tx_nofifo(cfg_tx_nofifo), .cfg_rx_nofifo(cfg_rx_nofifo),
        .cfg_tx_flush(cfg_tx_flush), .cfg_rx_flush(cfg_rx_flush),
        .cfg_ovf_w1c(cfg_ovf_w1c), .halt_o(halt_o), .tx_nofifo_o(tx_nofifo_o),
        .rx_nofifo_o(rx_nofifo_o), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_level(tx_level), .tx_avail(tx_avail),
        .tx_word(tx_word), .tx_take(tx_take), .rx_put(rx_put),
        .rx_pdata(rx_pdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_avail(rx_avail), .rx_level(rx_level), .rx_ovf(rx_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic h, input logic tn, input logic rn,
                          input logic tf, input logic rf, input logic oc);
        cfg_we = 1; cfg_halt = h; cfg_tx_nofifo = tn; cfg_rx_nofifo = rn;
        cfg_tx_flush = tf; cfg_rx_flush = rf; cfg_ovf_w1c = oc;
        tick();
        cfg_we = 0; cfg_tx_flush = 0; cfg_rx_flush = 0; cfg_ovf_w1c = 0;
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        tx_push = 1; tx_wdata = d; tick(); tx_push = 0;
    endtask

    task automatic take_tx();
        tx_take = 1; tick(); tx_take = 0;
    endtask

    task automatic put_rx(input logic [DW-1:0] d);
        rx_put = 1; rx_pdata = d; tick(); rx_put = 0;
    endtask

    task automatic pop_rx();
        rx_pop = 1; tick(); rx_pop = 0;
    endtask

    task automatic t_reset();
        check("R1 halt", halt_o, 1);
        check("R1 tx_nofifo", tx_nofifo_o, 0);
        check("R1 rx_nofifo", rx_nofifo_o, 0);
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_full", tx_full, 0);
        check("R1 rx_ovf", rx_ovf, 0);
    endtask

    task automatic t_halted_io();
        push_tx(8'hA1);
        check("R2 tx push ignored", tx_level, 0);
        put_rx(8'hB1);
        check("R2 rx put ignored", rx_level, 0);
    endtask

    task automatic t_lock();
        wr_cfg(1, 1, 1, 0, 0, 0);
        check("R3 tx lock", tx_nofifo_o, 0);
        check("R3 rx lock", rx_nofifo_o, 0);
        wr_cfg(0, 1, 1, 0, 0, 0);
        check("R3 halt writable", halt_o, 0);
        check("R3 lock uses old halt", tx_nofifo_o, 0);
        wr_cfg(0, 1, 1, 0, 0, 0);
        check("R3 tx write", tx_nofifo_o, 1);
        check("R3 rx write", rx_nofifo_o, 1);
        wr_cfg(0, 0, 0, 0, 0, 0);
        check("R3 restore", {tx_nofifo_o, rx_nofifo_o}, 0);
    endtask

    task automatic t_tx_fifo();
        for (int i = 1; i <= 5; i++) push_tx(8'(i * 8'h11));
        check("R4 level", tx_level, 4);
        check("R4 full", tx_full, 1);
        for (int i = 1; i <= 4; i++) begin
            check("R4 order", tx_word, 8'(i * 8'h11));
            take_tx();
        end
        check("R4 drained", tx_level, 0);
        check("R4 avail", tx_avail, 0);
    endtask

    task automatic t_tx_byp();
        wr_cfg(0, 1, 0, 0, 0, 0);
        push_tx(8'hC1); push_tx(8'hC2);
        check("R5 full at 2", tx_full, 1);
        push_tx(8'hC3);
        check("R5 level", tx_level, 2);
        check("R5 word0", tx_word, 8'hC1);
        take_tx();
        check("R5 word1", tx_word, 8'hC2);
        take_tx();
        check("R5 empty", tx_level, 0);
        wr_cfg(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rx_fifo();
        for (int i = 0; i < 4; i++) put_rx(8'(8'h30 + i));
        check("R6 level", rx_level, 4);
        check("R6 avail", rx_avail, 1);
        for (int i = 0; i < 4; i++) begin
            check("R6 order", rx_rdata, 8'(8'h30 + i));
            pop_rx();
        end
        check("R6 avail empty", rx_avail, 0);
    endtask

    task automatic t_rx_byp();
        wr_cfg(0, 0, 1, 0, 0, 0);
        put_rx(8'h41); put_rx(8'h42); put_rx(8'h43);
        check("R7 level", rx_level, 2);
        check("R7 ovf", rx_ovf, 1);
        check("R7 word0", rx_rdata, 8'h41);
        pop_rx();
        check("R7 word1", rx_rdata, 8'h42);
        pop_rx();
        wr_cfg(0, 0, 0, 0, 0, 1);
        check("R7 cleared", rx_ovf, 0);
    endtask

    task automatic t_ovf();
        for (int i = 0; i < 4; i++) put_rx(8'(8'h50 + i));
        rx_put = 1; rx_pdata = 8'h5F; rx_pop = 1; tick(); rx_put = 0; rx_pop = 0;
        check("R8 drop with pop level", rx_level, 3);
        check("R8 flag", rx_ovf, 1);
        check("R8 head", rx_rdata, 8'h51);
        tick(); tick();
        check("R8 sticky", rx_ovf, 1);
        put_rx(8'h54);
        rx_put = 1; rx_pdata = 8'h5E;
        wr_cfg(0, 0, 0, 0, 0, 1);
        rx_put = 0;
        check("R8 set wins", rx_ovf, 1);
        wr_cfg(0, 0, 0, 0, 0, 1);
        check("R8 w1c", rx_ovf, 0);
        check("R8 dropped word absent", rx_level, 4);
        wr_cfg(0, 0, 0, 0, 1, 0);
        check("R10 plain flush", rx_level, 0);
    endtask

    task automatic t_flush();
        push_tx(8'h61); push_tx(8'h62);
        wr_cfg(0, 0, 0, 0, 0, 0);
        check("R9 zero bit no effect", tx_level, 2);
        tx_push = 1; tx_wdata = 8'h63;
        wr_cfg(0, 0, 0, 1, 0, 0);
        tx_push = 0;
        check("R9 flush beats push", tx_level, 0);
        tick();
        check("R9 no stored flush", tx_level, 0);
        push_tx(8'h64);
        check("R9 after flush word", tx_word, 8'h64);
        put_rx(8'h71); put_rx(8'h72);
        wr_cfg(0, 0, 0, 0, 0, 0);
        check("R10 zero bit no effect", rx_level, 2);
        rx_put = 1; rx_pdata = 8'h73;
        wr_cfg(0, 0, 0, 0, 1, 0);
        rx_put = 0;
        check("R10 flush beats put", rx_level, 0);
        put_rx(8'h74);
        check("R10 realigned", rx_rdata, 8'h74);
        pop_rx();
        wr_cfg(1, 0, 0, 0, 0, 0);
        wr_cfg(1, 0, 0, 1, 0, 0);
        check("R2 flush ignored", tx_level, 1);
        take_tx();
        check("R2 take ignored", tx_level, 1);
        wr_cfg(0, 0, 0, 0, 0, 0);
        wr_cfg(0, 0, 0, 1, 0, 0);
        check("R9 flush after resume", tx_level, 0);
    endtask

    task automatic t_stale();
        for (int i = 0; i < 4; i++) put_rx(8'(8'h80 + i));
        put_rx(8'hE5);
        check("R11 ovf set", rx_ovf, 1);
        wr_cfg(0, 0, 0, 0, 1, 0);
        check("R11 level zero", rx_level, 0);
        check("R11 stale word", rx_rdata, 8'hE5);
        check("R10 flush keeps ovf", rx_ovf, 1);
        pop_rx();
        check("R11 dummy pop level", rx_level, 0);
        put_rx(8'h61);
        check("R11 clean frame", rx_rdata, 8'h61);
        check("R11 clean level", rx_level, 1);
        pop_rx();
        for (int i = 0; i < 4; i++) put_rx(8'(8'h90 + i));
        put_rx(8'h77);
        wr_cfg(0, 0, 0, 0, 1, 0);
        put_rx(8'h88);
        check("R11 stale counted", rx_level, 2);
        check("R11 stale first", rx_rdata, 8'h77);
        pop_rx();
        check("R11 new second", rx_rdata, 8'h88);
        check("R11 level after", rx_level, 1);
        pop_rx();
        check("R11 empty", rx_level, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_halted_io();
        t_lock();
        t_tx_fifo();
        t_tx_byp();
        t_rx_fifo();
        t_rx_byp();
        t_ovf();
        t_flush();
        t_stale();
        finish_run();
    end

endmodule